// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on a single output line. A one-character holding register sits in front of a frame shifter, so a new character can be accepted while the previous one is still leaving the line. Two flags report the state of each stage separately: one shows that the holding register can take a character, the other that the shifter is idle.

All timing comes from the transmit clock. Each serial bit lasts 1, 16 or 64 clock cycles, as the rate factor input selects. Character length (5 to 8 bits), parity (off, even or odd) and the number of stop bits (one or two) come from static configuration inputs. A separate enable input gates transmission. A surrounding register block supplies these inputs. Baud clock generation is done elsewhere.

Top module: `async_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `tx_rdy` is 1 and `tx_empty` is 1.
- R2: A `wr_stb` pulse while `tx_rdy` is 1 stores `wr_data` and clears `tx_rdy` from the next cycle. A `wr_stb` while `tx_rdy` is 0 is ignored and leaves the stored character unchanged.
- R3: When the holding register is full, the shifter is idle and `tx_en` is 1, the next clock edge moves the character into the shifter. After that edge `tx_rdy` is 1, `tx_empty` is 0 and `txd` drives the start bit.
- R4: A frame is one start bit at 0, then the data bits least significant first, then stop bits at 1. The character length is 5, 6, 7 or 8 bits for `cfg_len` 00, 01, 10 or 11. Only the low bits of the character are sent. `cfg_stop2` = 1 gives two stop bits and 0 gives one.
- R5: With `cfg_par_en` = 1, a parity bit follows the last data bit. For `cfg_par_odd` = 0 it is the XOR of the sent data bits. For `cfg_par_odd` = 1 it is the inverse of that XOR.
- R6: Every bit of a frame lasts 1, 16 or 64 clock cycles for `cfg_factor` 00, 01 or 10. The code 11 acts as 64.
- R7: If a character is waiting when the last stop bit ends, its start bit follows directly on the next cycle, with no idle bit between the frames.
- R8: `tx_empty` is 1 exactly when no frame is in progress, and `txd` is 1 whenever `tx_empty` is 1.
- R9: While `tx_en` is 0, no frame starts. A frame in progress is dropped, and `txd` is 1 from the next cycle. The holding register keeps its character and still accepts writes.
- R10: The configuration is captured when a frame is loaded. Changes to it during the frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, running at 1, 16 or 64 times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| cfg_factor | input | 2 | Clocks per bit: 00=1, 01=16, 10/11=64 |
| cfg_len | input | 2 | Character length: 00=5 through 11=8 bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| wr_stb | input | 1 | Single-cycle character write strobe |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output line, idle high |
| tx_rdy | output | 1 | Holding register empty |
| tx_empty | output | 1 | Shifter idle |

## Verification
The assertions expect inputs that change only between clock edges and a `wr_stb` that lasts a single cycle. They also rely on `tx_en` being sampled at the same edge as the flags it controls. The bench drives every input on the falling edge, so each rising edge sees settled values, and it pulses `wr_stb` for exactly one cycle. The bench also drives some writes while the holding register is full and some configuration changes in the middle of a frame. These cases fall within those assumptions and exercise the ignore and capture rules directly.

// File: rtl/async_tx_dbuf.sv
module async_tx_dbuf #(
  parameter int DATA_W = 8,
  parameter int MID_DIV = 16,
  parameter int HI_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [1:0]        cfg_factor,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_rdy,
  output logic              tx_empty
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int NB_W = $clog2(FRAME_W + 1);
  localparam int CNT_W = $clog2(HI_DIV);
  localparam logic [CNT_W-1:0] MID_M1 = CNT_W'(MID_DIV - 1);
  localparam logic [CNT_W-1:0] HI_M1 = CNT_W'(HI_DIV - 1);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic [FRAME_W-1:0] frame;
  logic [NB_W-1:0]   bits_left;
  logic [CNT_W-1:0]  tick;
  logic [CNT_W-1:0]  div_m1;

  function automatic logic [FRAME_W-1:0] mk_frame(
    input logic [DATA_W-1:0] d,
    input logic [1:0]        lc,
    input logic              pe,
    input logic              po
  );
    int len;
    logic p;
    logic [FRAME_W-1:0] f;
    len = DATA_W - 3 + int'(lc);
    f = '1;
    f[0] = 1'b0;
    p = po;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < len) begin
        f[i+1] = d[i];
        p = p ^ d[i];
      end
    end
    if (pe) f[len+1] = p;
    return f;
  endfunction

  logic             bit_end, last_bit, do_load, wr_ok;
  logic [CNT_W-1:0] div_sel;
  logic [NB_W-1:0]  nb_next;

  assign bit_end  = busy && (tick == '0);
  assign last_bit = bit_end && (bits_left == NB_W'(1));
  assign do_load  = tx_en && hold_full && (!busy || last_bit);
  assign wr_ok    = wr_stb && !hold_full;
  assign div_sel  = (cfg_factor == 2'b00) ? '0 :
                    (cfg_factor == 2'b01) ? MID_M1 : HI_M1;
  assign nb_next  = NB_W'(DATA_W - 1) + NB_W'(cfg_len) + NB_W'(cfg_par_en) + NB_W'(cfg_stop2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (wr_ok) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end else if (do_load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      frame     <= '1;
      bits_left <= '0;
      tick      <= '0;
      div_m1    <= '0;
    end else if (!tx_en) begin
      busy <= 1'b0;
    end else if (do_load) begin
      busy      <= 1'b1;
      frame     <= mk_frame(hold_data, cfg_len, cfg_par_en, cfg_par_odd);
      bits_left <= nb_next;
      tick      <= div_sel;
      div_m1    <= div_sel;
    end else if (last_bit) begin
      busy <= 1'b0;
    end else if (bit_end) begin
      frame     <= {1'b1, frame[FRAME_W-1:1]};
      bits_left <= bits_left - NB_W'(1);
      tick      <= div_m1;
    end else if (busy) begin
      tick <= tick - CNT_W'(1);
    end
  end

  assign txd      = !busy || frame[0];
  assign tx_rdy   = !hold_full;
  assign tx_empty = !busy;
endmodule

module async_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_stb,
  input logic txd,
  input logic tx_rdy,
  input logic tx_empty
);
  p_rdy_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_rdy) |=> !tx_rdy);
  p_hold_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rdy && !tx_en) |=> !tx_rdy);
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rdy && tx_empty && tx_en) |=> (tx_rdy && !tx_empty));
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> !txd);
  p_idle_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);
  p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (txd && tx_empty));
endmodule

bind async_tx_dbuf async_tx_dbuf_chk u_chk (.*);

// File: tb/sim_async_tx_dbuf.sv
module sim_async_tx_dbuf;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0;
  logic [1:0] cfg_factor = 2'b00, cfg_len = 2'b11;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, tx_rdy, tx_empty;

  async_tx_dbuf u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference model
  bit m_full = 0, m_busy = 0;
  int m_data = 0, m_per = 1, m_cnt = 0;
  bit m_bits[$];

  always @(posedge clk) begin
    bit bend, last, load, wok;
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_bits.delete(); m_cnt = 0;
    end else begin
      bend = m_busy && (m_cnt == m_per - 1);
      last = bend && (m_bits.size() == 1);
      load = tx_en && m_full && (!m_busy || last);
      wok  = wr_stb && !m_full;
      if (!tx_en) begin
        m_busy = 0; m_bits.delete();
      end else if (load) begin
        int len; bit p;
        len = 5 + cfg_len;
        p = cfg_par_odd;
        m_bits.delete();
        m_bits.push_back(1'b0);
        for (int i = 0; i < len; i++) begin
          m_bits.push_back(m_data[i]);
          p ^= m_data[i];
        end
        if (cfg_par_en) m_bits.push_back(p);
        m_bits.push_back(1'b1);
        if (cfg_stop2) m_bits.push_back(1'b1);
        m_per = (cfg_factor == 0) ? 1 : (cfg_factor == 1) ? 16 : 64;
        m_cnt = 0; m_busy = 1;
      end else if (last) begin
        m_busy = 0; m_bits.delete();
      end else if (bend) begin
        void'(m_bits.pop_front()); m_cnt = 0;
      end else if (m_busy) begin
        m_cnt++;
      end
      if (wok) begin m_full = 1; m_data = wr_data; end
      else if (load) m_full = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit etxd;
      etxd = m_busy ? m_bits[0] : 1'b1;
      cycles++;
      chk(cur_req, "txd", txd, etxd);
      chk(cur_req, "tx_rdy", tx_rdy, !m_full);
      chk(cur_req, "tx_empty", tx_empty, !m_busy);
    end
  end

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    int n = 0;
    while (!tx_rdy && n < 5000) begin @(negedge clk); n++; end
    write_byte(d);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!(tx_rdy && tx_empty) && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "txd", txd, 1); chk("R1", "tx_rdy", tx_rdy, 1); chk("R1", "tx_empty", tx_empty, 1);

    cur_req = "R2";
    write_byte(8'hA5);
    #1 chk("R2", "tx_rdy after write", tx_rdy, 0);
    write_byte(8'h3C);
    repeat (5) @(negedge clk);
    chk("R9", "txd while disabled", txd, 1);
    chk("R9", "tx_empty while disabled", tx_empty, 1);

    cur_req = "R3";
    tx_en = 1'b1;
    @(negedge clk);
    chk("R3", "tx_rdy after load", tx_rdy, 1);
    chk("R3", "tx_empty after load", tx_empty, 0);
    chk("R4", "start bit", txd, 0);
    @(negedge clk);
    chk("R2", "first data bit of kept byte", txd, 1);
    wait_idle();

    cur_req = "R4";
    for (int l = 0; l < 4; l++) begin
      cfg_len = 2'(l); cfg_stop2 = l[0];
      send(8'h47 ^ 8'(l * 37));
      wait_idle();
    end

    cur_req = "R5";
    cfg_len = 2'b10; cfg_par_en = 1'b1;
    cfg_par_odd = 1'b0; send(8'h49); wait_idle();
    cfg_par_odd = 1'b1; send(8'h49); wait_idle();
    cfg_par_odd = 1'b0; send(8'h03); wait_idle();
    cfg_len = 2'b00; cfg_par_odd = 1'b1; send(8'hFF); wait_idle();

    cur_req = "R6";
    cfg_par_en = 1'b0; cfg_len = 2'b11; cfg_stop2 = 1'b1;
    for (int f = 1; f < 4; f++) begin
      cfg_factor = 2'(f);
      send(8'h96);
      wait_idle();
    end

    cur_req = "R7";
    cfg_factor = 2'b00; cfg_stop2 = 1'b0;
    send(8'h11); send(8'hEE); send(8'h5A);
    wait_idle();
    cfg_factor = 2'b01; cfg_par_en = 1'b1;
    send(8'h81); send(8'h7E);
    wait_idle();

    cur_req = "R10";
    send(8'hC3);
    repeat (20) @(negedge clk);
    cfg_factor = 2'b00; cfg_len = 2'b00; cfg_par_en = 1'b0; cfg_stop2 = 1'b1;
    wait_idle();

    cur_req = "R9";
    cfg_factor = 2'b01;
    send(8'h0F);
    repeat (40) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R9", "txd after abort", txd, 1);
    send(8'hF0);
    repeat (30) @(negedge clk);
    chk("R9", "tx_rdy held while disabled", tx_rdy, 0);
    tx_en = 1'b1;
    wait_idle();

    cur_req = "R8";
    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule